// File: doc/BRIEF.md
# Stipple and Block-Copy Pixel Engine

This block is a write-driven 2D drawing accelerator attached to an 8-bit-per-pixel frame store. It holds the frame store itself as a single-port pixel RAM. Software issues commands by writing to it. The write address always selects the destination pixel. The data word then says what to draw. A stipple command turns a 32-bit mask into writes of a stored foreground colour. A blit command either paints a run of 1 to 32 pixels with that colour or copies a run from another pixel index. A separate command loads the colour.

Every command goes through one request channel with a valid/ready handshake. Drawing commands run sequentially on the RAM, and the engine reports busy until the last pixel has been written. While it is busy it refuses new commands. Reads on the command channel return zero. A small inspection port reads single pixels back while the engine is idle.

Top module: `stbl_engine`

## Requirements
- R1: After synchronous reset, `cmd_ready` is 1 and `busy`, `rsp_valid` and `pix_rd_valid` are 0.
- R2: The destination pixel of a drawing command is `cmd_addr[22:3]` (the address shifted right by three and kept to 20 bits), reduced modulo the RAM depth of 2^PIX_AW. Successive pixels of a run advance by one and wrap modulo the depth.
- R3: A stipple write (`cmd_op`=2'b01) maps data bit 31-i to destination pixel dst+i for i = 0..31. Each set bit writes the foreground colour and each clear bit leaves its pixel unchanged. `busy` stays high for exactly 32 cycles.
- R4: A blit write (`cmd_op`=2'b10) takes its source index from data bits 23:0 and its run length minus one from bits 28:24, so runs are 1 to 32 pixels long. Data bits 31:29 have no effect.
- R5: A blit whose source field equals 24'hFFFFFF fills the run with the foreground colour, and `busy` stays high for exactly length cycles.
- R6: A blit with any other source field copies pixel (src+i) mod depth to (dst+i) mod depth in ascending order of i, one pixel every two cycles, so `busy` stays high for 2×length cycles. An overlapping run with the source below the destination repeats the pattern forward, exactly as a sequential ascending copy would.
- R7: A colour write (`cmd_op`=2'b00) loads the low 8 bits of the data word as the foreground colour. The colour is kept until the next colour write, and loading it does not raise `busy`.
- R8: Write sizes `cmd_size`=2'b10 (4 bytes) and 2'b11 (8 bytes) behave the same and use only `cmd_data[31:0]`. A write with any other size code is accepted and has no effect.
- R9: A read (`cmd_we`=0) of any window is accepted while idle, gives `rsp_valid`=1 with `rsp_data`=0 in the cycle after acceptance, leaves `busy` low and changes no pixel.
- R10: `busy` rises in the cycle after a drawing command is accepted and falls after the last pixel write. `cmd_ready` is 0 whenever `busy` is 1, and a command held valid during that time is accepted once the engine is idle.
- R11: A `pix_rd_en` request made while idle returns the pixel at `pix_rd_addr` with `pix_rd_valid`=1 in the next cycle. A request made while busy is dropped, and `pix_rd_valid` stays 0.
- R12: A write with the reserved opcode `cmd_op`=2'b11 is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_op | input | 2 | 00 colour, 01 stipple, 10 blit, 11 reserved |
| cmd_size | input | 2 | Access size code: 10 = 4 bytes, 11 = 8 bytes |
| cmd_addr | input | ADDR_W | Byte address within the command window |
| cmd_data | input | 64 | Write data; only bits 31:0 are used |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data, always zero |
| busy | output | 1 | Drawing command in progress |
| pix_rd_en | input | 1 | Pixel inspection read request |
| pix_rd_addr | input | PIX_AW | Pixel index to inspect |
| pix_rd_valid | output | 1 | Inspection data valid |
| pix_rd_data | output | PIX_W | Inspected pixel value |

## Verification
The bench goes after run boundaries: lengths 1 and 32, runs that wrap past the top of a 256-pixel store, and address or source bits above the RAM range. A design that got these wrong would write one pixel too few or too many, or would corrupt pixels at the bottom of memory. Overlapping copies in both directions are checked against a sequential reference. A design that read ahead or buffered would copy stale data and not repeat the pattern forward. The bench also checks the reserved fill source next to the value one below it, bit order within the stipple mask, and the upper data word and upper blit bits that must be ignored. Busy durations are counted exactly, so an engine that finishes early, stalls, or accepts a command under back-pressure shows up as a wrong count or a wrong image.

// File: rtl/stbl_pkg.sv
package stbl_pkg;

  typedef enum logic [1:0] {
    OP_COLOR = 2'b00,
    OP_STIP  = 2'b01,
    OP_BLIT  = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STIP,
    ST_FILL,
    ST_CRD,
    ST_CWR
  } state_e;

  localparam int DST_FIELD_W = 20;
  localparam int SRC_FIELD_W = 24;
  localparam int LEN_W       = 5;
  localparam int WORD_W      = 32;
  localparam logic [SRC_FIELD_W-1:0] FILL_KEY = '1;

  typedef struct packed {
    logic                   color;
    logic                   stip;
    logic                   blit;
    logic                   rd;
    logic                   fill;
    logic [DST_FIELD_W-1:0] dst;
    logic [SRC_FIELD_W-1:0] src;
    logic [LEN_W-1:0]       len_m1;
    logic [WORD_W-1:0]      word;
  } cmd_t;

endpackage

// File: rtl/stbl_decode.sv
module stbl_decode
  import stbl_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              fire,
  input  logic              cmd_we,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_size,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [63:0]       cmd_data,
  output cmd_t              cmd
);

  localparam int DST_LSB = 3;
  localparam int DST_MSB = DST_LSB + DST_FIELD_W - 1;

  logic  size_ok;
  logic  wr_ok;
  op_e   op;
  logic  unused_bits;

  assign op      = op_e'(cmd_op);
  assign size_ok = cmd_size[1];
  assign wr_ok   = fire && cmd_we && size_ok;

  always_comb begin
    cmd        = '0;
    cmd.word   = cmd_data[WORD_W-1:0];
    cmd.dst    = cmd_addr[DST_MSB:DST_LSB];
    cmd.src    = cmd.word[SRC_FIELD_W-1:0];
    cmd.len_m1 = cmd.word[SRC_FIELD_W +: LEN_W];
    cmd.fill   = (cmd.src == FILL_KEY);
    cmd.color  = wr_ok && (op == OP_COLOR);
    cmd.stip   = wr_ok && (op == OP_STIP);
    cmd.blit   = wr_ok && (op == OP_BLIT);
    cmd.rd     = fire && !cmd_we;
  end

  assign unused_bits = ^{cmd_data[63:WORD_W], cmd_addr[DST_LSB-1:0],
                         cmd_addr >> (DST_MSB + 1), cmd_size[0]};

endmodule

// File: rtl/stbl_pixram.sv
module stbl_pixram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    rdata <= mem[addr];
  end

endmodule

// File: rtl/stbl_seq.sv
module stbl_seq
  import stbl_pkg::*;
#(
  parameter int PIX_AW = 10,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_t              cmd,
  input  logic [PIX_W-1:0]  colour,
  input  logic [PIX_W-1:0]  ram_rdata,
  output logic              busy,
  output logic [PIX_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic [PIX_W-1:0]  ram_wdata
);

  state_e             state_q;
  logic [PIX_AW-1:0]  dst_q;
  logic [PIX_AW-1:0]  src_q;
  logic [LEN_W-1:0]   cnt_q;
  logic [WORD_W-1:0]  mask_q;
  logic               last;
  logic               unused_cmd;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      dst_q   <= '0;
      src_q   <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          dst_q <= cmd.dst[PIX_AW-1:0];
          src_q <= cmd.src[PIX_AW-1:0];
          if (cmd.stip) begin
            mask_q  <= cmd.word;
            cnt_q   <= LEN_W'(WORD_W - 1);
            state_q <= ST_STIP;
          end else if (cmd.blit) begin
            cnt_q   <= cmd.len_m1;
            state_q <= cmd.fill ? ST_FILL : ST_CRD;
          end
        end
        ST_STIP: begin
          mask_q <= mask_q << 1;
          dst_q  <= dst_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          if (last) state_q <= ST_IDLE;
        end
        ST_FILL: begin
          dst_q <= dst_q + 1'b1;
          cnt_q <= cnt_q - 1'b1;
          if (last) state_q <= ST_IDLE;
        end
        ST_CRD: begin
          state_q <= ST_CWR;
        end
        ST_CWR: begin
          dst_q   <= dst_q + 1'b1;
          src_q   <= src_q + 1'b1;
          cnt_q   <= cnt_q - 1'b1;
          state_q <= last ? ST_IDLE : ST_CRD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    ram_addr  = (state_q == ST_CRD) ? src_q : dst_q;
    ram_we    = ((state_q == ST_STIP) && mask_q[WORD_W-1]) ||
                (state_q == ST_FILL) || (state_q == ST_CWR);
    ram_wdata = (state_q == ST_CWR) ? ram_rdata : colour;
  end

  assign unused_cmd = ^{cmd.dst >> PIX_AW, cmd.src >> PIX_AW, cmd.rd, cmd.color};

endmodule

// File: rtl/stbl_engine.sv
module stbl_engine
  import stbl_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PIX_AW = 10,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_we,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_size,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [63:0]       cmd_data,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              busy,
  input  logic              pix_rd_en,
  input  logic [PIX_AW-1:0] pix_rd_addr,
  output logic              pix_rd_valid,
  output logic [PIX_W-1:0]  pix_rd_data
);

  cmd_t              dec;
  logic              fire;
  logic [PIX_W-1:0]  colour_q;
  logic              rsp_valid_q;
  logic              pix_valid_q;
  logic              eng_busy;
  logic [PIX_AW-1:0] eng_addr;
  logic              eng_we;
  logic [PIX_W-1:0]  eng_wdata;
  logic [PIX_AW-1:0] ram_addr;
  logic [PIX_W-1:0]  ram_rdata;

  assign cmd_ready = !eng_busy;
  assign fire      = cmd_valid && cmd_ready;

  stbl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .fire     (fire),
    .cmd_we   (cmd_we),
    .cmd_op   (cmd_op),
    .cmd_size (cmd_size),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .cmd      (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      colour_q    <= '0;
      rsp_valid_q <= 1'b0;
      pix_valid_q <= 1'b0;
    end else begin
      if (dec.color) colour_q <= dec.word[PIX_W-1:0];
      rsp_valid_q <= dec.rd;
      pix_valid_q <= pix_rd_en && !eng_busy;
    end
  end

  stbl_seq #(.PIX_AW(PIX_AW), .PIX_W(PIX_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd       (dec),
    .colour    (colour_q),
    .ram_rdata (ram_rdata),
    .busy      (eng_busy),
    .ram_addr  (eng_addr),
    .ram_we    (eng_we),
    .ram_wdata (eng_wdata)
  );

  assign ram_addr = eng_busy ? eng_addr : pix_rd_addr;

  stbl_pixram #(.AW(PIX_AW), .DW(PIX_W)) u_ram (
    .clk   (clk),
    .addr  (ram_addr),
    .we    (eng_we),
    .wdata (eng_wdata),
    .rdata (ram_rdata)
  );

  assign busy         = eng_busy;
  assign rsp_valid    = rsp_valid_q;
  assign rsp_data     = '0;
  assign pix_rd_valid = pix_valid_q;
  assign pix_rd_data  = ram_rdata;

endmodule

// File: rtl/stbl_engine_chk.sv
module stbl_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        cmd_we,
  input logic [1:0]  cmd_op,
  input logic [1:0]  cmd_size,
  input logic [28:0] cmd_word,
  input logic        busy,
  input logic        pix_rd_en,
  input logic        pix_rd_valid,
  input logic        rsp_valid
);

  localparam logic [1:0] K_STIP = 2'd0;
  localparam logic [1:0] K_FILL = 2'd1;
  localparam logic [1:0] K_COPY = 2'd2;

  logic       acc;
  logic       go;
  logic [1:0] kind_d;
  logic [6:0] len;
  logic [6:0] exp_d;
  logic [1:0] kind_q;
  logic [6:0] exp_q;
  logic [6:0] run_q;

  assign acc = cmd_valid && cmd_ready;
  assign go  = acc && cmd_we && cmd_size[1] && (cmd_op == 2'b01 || cmd_op == 2'b10);
  assign len = {2'b00, cmd_word[28:24]} + 7'd1;

  always_comb begin
    if (cmd_op == 2'b01) begin
      kind_d = K_STIP;
      exp_d  = 7'd32;
    end else if (cmd_word[23:0] == 24'hFFFFFF) begin
      kind_d = K_FILL;
      exp_d  = len;
    end else begin
      kind_d = K_COPY;
      exp_d  = len << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= K_STIP;
      exp_q  <= '0;
      run_q  <= '0;
    end else if (go) begin
      kind_q <= kind_d;
      exp_q  <= exp_d;
      run_q  <= '0;
    end else if (busy) begin
      run_q <= run_q + 7'd1;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    go |=> busy) else $error("busy not raised"); // R10

  AST_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_valid |=> $stable(kind_q) && $stable(exp_q)) else $error("command taken while busy"); // R10

  AST_STIP_CYCLES: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && kind_q == K_STIP |-> run_q == exp_q) else $error("stipple length"); // R3

  AST_FILL_CYCLES: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && kind_q == K_FILL |-> run_q == exp_q) else $error("fill length"); // R5

  AST_COPY_CYCLES: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && kind_q == K_COPY |-> run_q == exp_q) else $error("copy length"); // R6

  AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    acc && !cmd_we |=> rsp_valid && !busy) else $error("read response"); // R9

  AST_INERT_WRITE: assert property (@(posedge clk) disable iff (rst)
    acc && cmd_we && !go |=> !busy) else $error("inert write started engine"); // R12

  AST_PIX_DROP: assert property (@(posedge clk) disable iff (rst)
    pix_rd_en && busy |=> !pix_rd_valid) else $error("inspection while busy"); // R11

endmodule

bind stbl_engine stbl_engine_chk i_stbl_engine_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_we       (cmd_we),
  .cmd_op       (cmd_op),
  .cmd_size     (cmd_size),
  .cmd_word     (cmd_data[28:0]),
  .busy         (busy),
  .pix_rd_en    (pix_rd_en),
  .pix_rd_valid (pix_rd_valid),
  .rsp_valid    (rsp_valid)
);

// File: tb/test_stbl_engine.sv
module test_stbl_engine;

  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_we = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [1:0]    cmd_size = 2'b10;
  logic [23:0]   cmd_addr = '0;
  logic [63:0]   cmd_data = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_data;
  logic          busy;
  logic          pix_rd_en = 1'b0;
  logic [AW-1:0] pix_rd_addr = '0;
  logic          pix_rd_valid;
  logic [7:0]    pix_rd_data;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] ref_mem [DEPTH];
  logic [7:0] ref_col = 8'h00;

  always #10 clk = ~clk;

  stbl_engine #(.ADDR_W(24), .PIX_AW(AW), .PIX_W(8)) i_stbl_engine (
    .clk (clk), .rst (rst),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_we (cmd_we),
    .cmd_op (cmd_op), .cmd_size (cmd_size), .cmd_addr (cmd_addr),
    .cmd_data (cmd_data), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
    .busy (busy), .pix_rd_en (pix_rd_en), .pix_rd_addr (pix_rd_addr),
    .pix_rd_valid (pix_rd_valid), .pix_rd_data (pix_rd_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic we, input logic [1:0] sz,
                       input logic [23:0] addr, input logic [63:0] data);
    cmd_op = op; cmd_we = we; cmd_size = sz; cmd_addr = addr; cmd_data = data;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic int dst_of(input logic [23:0] addr);
    return int'(addr[22:3]) % DEPTH;
  endfunction

  task automatic m_stip(input logic [23:0] addr, input logic [31:0] mask);
    int d = dst_of(addr);
    for (int i = 0; i < 32; i++)
      if (mask[31-i]) ref_mem[(d + i) % DEPTH] = ref_col;
  endtask

  task automatic m_blit(input logic [23:0] addr, input logic [31:0] w);
    int d = dst_of(addr);
    int s = int'(w[23:0]) % DEPTH;
    int n = int'(w[28:24]) + 1;
    for (int i = 0; i < n; i++) begin
      if (w[23:0] == 24'hFFFFFF) ref_mem[(d + i) % DEPTH] = ref_col;
      else ref_mem[(d + i) % DEPTH] = ref_mem[(s + i) % DEPTH];
    end
  endtask

  task automatic set_col(input logic [31:0] v);
    issue(2'b00, 1'b1, 2'b10, 24'h0, {32'h0, v});
    ref_col = v[7:0];
  endtask

  // returns busy duration in cycles
  task automatic run(input logic [1:0] op, input logic [1:0] sz, input logic [23:0] addr,
                     input logic [63:0] data, output int cyc);
    issue(op, 1'b1, sz, addr, data);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    if (op == 2'b01) m_stip(addr, data[31:0]);
    else if (op == 2'b10) m_blit(addr, data[31:0]);
  endtask

  task automatic peek(input int a, output logic [7:0] v, output logic vld);
    wait_idle();
    pix_rd_en = 1'b1; pix_rd_addr = AW'(a);
    @(negedge clk);
    pix_rd_en = 1'b0;
    v = pix_rd_data; vld = pix_rd_valid;
  endtask

  task automatic compare_all(input string req);
    logic [7:0] v; logic vld;
    for (int a = 0; a < DEPTH; a++) begin
      peek(a, v, vld);
      chk(vld && v === ref_mem[a], req, {vld, v}, {1'b1, ref_mem[a]});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] v; logic vld;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready === 1'b1, "R1 ready", cmd_ready, 1);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(pix_rd_valid === 1'b0, "R1 pix_rd_valid", pix_rd_valid, 0);

    // Initialise each pixel with a distinct value through single-bit stipples (R3, R7)
    for (int a = 0; a < DEPTH; a++) begin
      set_col(32'h0 | ((a * 13 + 7) & 8'hFF));
      run(2'b01, 2'b10, 24'(a << 3), 64'h8000_0000, cyc);
    end
    compare_all("R3 init");

    // R7: colour from low byte only, upper bits ignored
    set_col(32'hABCD_EF5C);
    chk(busy === 1'b0, "R7 colour no busy", busy, 0);
    run(2'b01, 2'b10, 24'd40 << 3, 64'h0000_0001, cyc);
    chk(cyc == 32, "R3 stipple duration", cyc, 32);
    compare_all("R7 colour byte");

    // R3 stipple patterns, including wrap and empty mask; R2 address bits
    begin
      logic [31:0] masks [6] = '{32'hFFFF_FFFF, 32'h0, 32'hA5A5_A5A5, 32'h1234_5678, 32'h8000_0001, 32'h7FFF_FFFE};
      int dsts [6] = '{240, 10, 100, 0, 255, 225};
      for (int k = 0; k < 6; k++) begin
        set_col(32'(8'h30 + k * 17));
        // low 3 bits and bits 22:11 and 23 set: R2
        run(2'b01, 2'b10, 24'((dsts[k] << 3) | 3'b101 | (k[0] ? 24'h80_0000 : 24'h1_5800)), {32'h0, masks[k]}, cyc);
        chk(cyc == 32, "R3 stipple duration", cyc, 32);
        compare_all("R3 R2 stipple");
      end
    end

    // R5 fill sweep over all lengths; R4 upper bits ignored
    for (int l = 1; l <= 32; l++) begin
      logic [31:0] w;
      set_col(32'(l * 7 + 3));
      w = {3'(l), 5'(l - 1), 24'hFFFFFF};
      run(2'b10, 2'b10, 24'(((l * 37) % DEPTH) << 3), {32'hDEAD_BEEF, w}, cyc);
      chk(cyc == l, "R5 fill duration", cyc, l);
      compare_all("R5 R4 fill");
    end

    // R6 copies: disjoint, overlap both ways, source wrap, high source bits
    begin
      int lens [6] = '{1, 2, 5, 16, 31, 32};
      for (int k = 0; k < 6; k++) begin
        int l = lens[k];
        int s = (k * 41 + 3) % DEPTH;
        int dd [4];
        logic [23:0] sf [4];
        dd[0] = (s + 100) % DEPTH; sf[0] = 24'(s);
        dd[1] = (s + 3) % DEPTH;   sf[1] = 24'(s);
        dd[2] = s;                 sf[2] = 24'((s + 2) % DEPTH);
        dd[3] = (s + 60) % DEPTH;  sf[3] = 24'h12_3400 | 24'((s + 250) % DEPTH);
        for (int c = 0; c < 4; c++) begin
          run(2'b10, 2'b11, 24'(dd[c] << 3), {32'hFFFF_FFFF, 3'b111, 5'(l - 1), sf[c]}, cyc);
          chk(cyc == 2 * l, "R6 copy duration", cyc, 2 * l);
          compare_all("R6 copy");
        end
      end
    end

    // R5/R6 boundary: source one below the fill key is a copy
    run(2'b10, 2'b10, 24'd20 << 3, {32'h0, 8'd3, 24'hFFFFFE}, cyc);
    chk(cyc == 8, "R6 FFFFFE is copy", cyc, 8);
    compare_all("R6 FFFFFE copy");

    // R8 invalid size codes ignored; 8-byte stipple uses low word only
    for (int sz = 0; sz < 2; sz++) begin
      issue(2'b01, 1'b1, 2'(sz), 24'd50 << 3, 64'hFFFF_FFFF);
      chk(busy === 1'b0, "R8 bad size no busy", busy, 0);
      issue(2'b00, 1'b1, 2'(sz), 24'h0, 64'h11);
    end
    compare_all("R8 bad size");
    set_col(32'h77);
    run(2'b01, 2'b11, 24'd60 << 3, 64'hFFFF_FFFF_0000_F000, cyc);
    compare_all("R8 wide write");

    // R12 reserved opcode
    issue(2'b11, 1'b1, 2'b10, 24'd5 << 3, 64'hFFFF_FFFF);
    chk(busy === 1'b0, "R12 reserved no busy", busy, 0);
    compare_all("R12 reserved");

    // R9 reads of each window return zero
    for (int op = 0; op < 4; op++) begin
      issue(2'(op), 1'b0, 2'b10, 24'd8 << 3, 64'hFFFF_FFFF);
      chk(rsp_valid === 1'b1 && rsp_data === 32'h0, "R9 read data", {rsp_valid, rsp_data}, {1'b1, 32'h0});
      chk(busy === 1'b0, "R9 read no busy", busy, 0);
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R9 single response", rsp_valid, 0);
    end
    set_col(32'h99);
    run(2'b01, 2'b10, 24'd70 << 3, 64'h8000_0000, cyc);
    compare_all("R9 R7 colour kept");

    // R10 back-pressure and R11 dropped inspection
    set_col(32'hC3);
    issue(2'b01, 1'b1, 2'b10, 24'd150 << 3, 64'hF0F0_F0F0);
    m_stip(24'd150 << 3, 32'hF0F0_F0F0);
    chk(cmd_ready === 1'b0 && busy === 1'b1, "R10 ready low while busy", cmd_ready, 0);
    pix_rd_en = 1'b1; pix_rd_addr = 8'd3;
    @(negedge clk);
    pix_rd_en = 1'b0;
    chk(pix_rd_valid === 1'b0, "R11 dropped while busy", pix_rd_valid, 0);
    issue(2'b10, 1'b1, 2'b10, 24'd152 << 3, {32'h0, 8'd7, 24'd150});
    chk(busy === 1'b1, "R10 held command accepted", busy, 1);
    m_blit(24'd152 << 3, {8'd7, 24'd150});
    wait_idle();
    compare_all("R10 back-pressure");
    peek(150, v, vld);
    chk(vld === 1'b1 && v === 8'hC3, "R11 inspection", v, 8'hC3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule